// File: doc/BRIEF.md
# IDE Channel Interrupt Status Latch

This block holds one sticky interrupt-pending flag for each of two IDE channels. Each channel's drive interrupt status bit, as delivered by the bus-master engine, sets its flag. A deasserted status never clears a flag. Software sees the flags in two places: in two configuration registers, and in a vendor byte of the bus-master I/O window. It clears them either by reading the configuration register, which clears the flag after the read, or by writing a one to the matching bit of the vendor byte.

The block sits between the I/O window decoder and the standard bus-master register logic. It overlays the vendor byte on the read data and marks bit 3 of both status bytes. It also trims the write data that goes on to the standard logic. In the extended variant, two mask bits stored in the vendor byte stop each channel's interrupt from reaching the bus-master status. All state updates on one clock edge, with an active-low synchronous reset.

Top module: `chan_irq_latch`

## Requirements
- R1: After reset both flags and the stored vendor nibble are zero. A read of I/O offset 1 returns 0x00, and configuration reads of 0x50 and 0x57 return 0x00.
- R2: A drive status bit of 1 on channel c sets flag c at the next clock edge. A status of 0 leaves a set flag set.
- R3: While a configuration read strobe names address 0x50, the configuration read data carries the channel 0 flag at bit 2 and zeros elsewhere. The channel 0 flag is clear from the next edge. The channel 1 flag is untouched.
- R4: While a configuration read strobe names address 0x57, the configuration read data carries the channel 1 flag at bit 4 and zeros elsewhere. The channel 1 flag is clear from the next edge. The channel 0 flag is untouched.
- R5: An I/O write to offset 1 clears the channel 0 flag when data bit 2 is 1, and clears the channel 1 flag when data bit 3 is 1. A zero in either bit leaves that flag unchanged.
- R6: An I/O write to offset 1 stores data bits 7:4. A read of offset 1 returns the stored nibble in bits 7:4, the channel 1 flag at bit 3, the channel 0 flag at bit 2, and zeros in bits 1:0.
- R7: The write data passed to the standard bus-master logic is the data with bits 7:2 forced to zero for offset 1, and the unchanged data for every other offset.
- R8: A read of offset 2 or offset 0xA returns the standard read data with bit 3 forced to one. Offsets other than 1, 2 and 0xA return the standard read data unchanged.
- R9: In the extended variant, the forwarded interrupt of channel 0 is the drive status ANDed with the inverse of stored bit 4. Channel 1 is gated the same way by stored bit 5.
- R10: If a clear (from either path) and a drive status of 1 reach the same channel in the same cycle, the flag is set after the edge.
- R11: A configuration read of any other address returns 0x00 and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_irq | input | 2 | Drive interrupt status bit per channel |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_rdata | output | 8 | Flag bits for the addressed configuration register |
| io_wr | input | 1 | Bus-master I/O window write strobe |
| io_addr | input | 4 | Bus-master I/O window offset |
| io_wdata | input | 8 | I/O write data |
| bm_rdata | input | 8 | Read data from the standard bus-master logic |
| io_rdata | output | 8 | Read data returned for the I/O window |
| io_pass_wdata | output | 8 | Write data handed to the standard bus-master logic |
| bm_irq_fwd | output | 2 | Per-channel interrupt forwarded to the bus-master status |

## Verification
A flag stuck low shows up one edge after a drive status pulse, at bit 2 or 3 of the offset-1 read. A flag that fails to clear shows up one edge after a configuration read or a vendor write. Crossed channel wiring is caught by sweeping every two-flag pattern through both clear paths, each time checking that the channel not addressed is left alone. A wrong stored nibble shows up in the read data and the forwarding masks on the very next cycle. The combinational overlays are swept over every offset and data byte.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NCH      = 2;
  localparam int CFG_AW   = 8;
  localparam int IO_AW    = 4;
  localparam int DW       = 8;
  localparam logic [CFG_AW-1:0] CFG_FLAG0_ADDR = 8'h50;
  localparam logic [CFG_AW-1:0] CFG_FLAG1_ADDR = 8'h57;
  localparam int CFG_FLAG0_BIT = 2;
  localparam int CFG_FLAG1_BIT = 4;
  localparam logic [IO_AW-1:0] IO_VEND_OFS = 4'h1;
  localparam logic [IO_AW-1:0] IO_ST0_OFS  = 4'h2;
  localparam logic [IO_AW-1:0] IO_ST1_OFS  = 4'hA;

  function automatic logic [DW-1:0] vend_view(input logic [3:0] nib, input logic [NCH-1:0] flg);
    return {nib, flg[1], flg[0], 2'b00};
  endfunction

  function automatic logic [DW-1:0] pass_wr(input logic [IO_AW-1:0] ofs, input logic [DW-1:0] wd);
    return (ofs == IO_VEND_OFS) ? {6'b0, wd[1:0]} : wd;
  endfunction

  function automatic logic [DW-1:0] cfg_view(input logic [CFG_AW-1:0] addr, input logic [NCH-1:0] flg);
    logic [DW-1:0] r;
    r = '0;
    if (addr == CFG_FLAG0_ADDR) r[CFG_FLAG0_BIT] = flg[0];
    if (addr == CFG_FLAG1_ADDR) r[CFG_FLAG1_BIT] = flg[1];
    return r;
  endfunction
endpackage

// File: rtl/chan_flag_cell.sv
module chan_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic clr_in,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (irq_in) flag_o <= 1'b1;
    else if (clr_in) flag_o <= 1'b0;
  end

  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n) irq_in |=> flag_o);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n) (flag_o && !clr_in) |=> flag_o);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n) (clr_in && irq_in) |=> flag_o);
  a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n) (clr_in && !irq_in) |=> !flag_o);
endmodule

// File: rtl/vend_io_window.sv
module vend_io_window
  import chan_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic [DW-1:0]    bm_rdata,
  input  logic [NCH-1:0]   flags,
  output logic [DW-1:0]    io_rdata,
  output logic [DW-1:0]    io_pass_wdata,
  output logic [NCH-1:0]   io_clr,
  output logic [3:0]       nib_q
);
  logic vend_hit;
  assign vend_hit = (io_addr == IO_VEND_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n)                nib_q <= '0;
    else if (io_wr && vend_hit) nib_q <= io_wdata[7:4];
  end

  assign io_clr = (io_wr && vend_hit) ? io_wdata[3:2] : '0;
  assign io_pass_wdata = pass_wr(io_addr, io_wdata);

  always_comb begin
    io_rdata = bm_rdata;
    if (vend_hit) io_rdata = vend_view(nib_q, flags);
    else if (io_addr == IO_ST0_OFS || io_addr == IO_ST1_OFS) io_rdata = bm_rdata | 8'h08;
  end

  a_r6_nib_store: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IO_VEND_OFS) |=> (nib_q == $past(io_wdata[7:4])));
  a_r6_nib_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == IO_VEND_OFS) |=> $stable(nib_q));
  a_r8_status_bit3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == IO_ST0_OFS || io_addr == IO_ST1_OFS) |-> io_rdata[3]);
endmodule

// File: rtl/chan_irq_latch.sv
module chan_irq_latch
  import chan_irq_pkg::*;
#(
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        drv_irq,
  input  logic              cfg_rd,
  input  logic [7:0]        cfg_addr,
  output logic [7:0]        cfg_rdata,
  input  logic              io_wr,
  input  logic [3:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic [7:0]        bm_rdata,
  output logic [7:0]        io_rdata,
  output logic [7:0]        io_pass_wdata,
  output logic [1:0]        bm_irq_fwd
);
  logic [NCH-1:0] flags;
  logic [NCH-1:0] io_clr;
  logic [NCH-1:0] cfg_clr;
  logic [NCH-1:0] clr_any;
  logic [NCH-1:0] fwd_mask;
  logic [3:0]     nib_q;

  assign cfg_clr[0] = cfg_rd && (cfg_addr == CFG_FLAG0_ADDR);
  assign cfg_clr[1] = cfg_rd && (cfg_addr == CFG_FLAG1_ADDR);
  assign clr_any    = cfg_clr | io_clr;
  assign cfg_rdata  = cfg_view(cfg_addr, flags);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (drv_irq[c]),
      .clr_in (clr_any[c]),
      .flag_o (flags[c])
    );
  end

  if (EXTENDED) begin : g_ext
    assign fwd_mask = nib_q[1:0];
  end else begin : g_base
    assign fwd_mask = '0;
  end

  assign bm_irq_fwd = drv_irq & ~fwd_mask;

  vend_io_window u_win (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .bm_rdata      (bm_rdata),
    .flags         (flags),
    .io_rdata      (io_rdata),
    .io_pass_wdata (io_pass_wdata),
    .io_clr        (io_clr),
    .nib_q         (nib_q)
  );

  a_r3_cfg_clear0: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == CFG_FLAG0_ADDR && !drv_irq[0]) |=> !flags[0]);
  a_r4_cfg_clear1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_addr == CFG_FLAG1_ADDR && !drv_irq[1]) |=> !flags[1]);
  a_r9_mask_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    (EXTENDED && nib_q[0]) |-> !bm_irq_fwd[0]);
  a_r9_mask_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    (EXTENDED && nib_q[1]) |-> !bm_irq_fwd[1]);
endmodule

// File: tb/chan_irq_latch_tb.sv
module chan_irq_latch_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] drv_irq = '0;
  logic cfg_rd = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_rdata;
  logic io_wr = 1'b0;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic [7:0] bm_rdata = '0;
  logic [7:0] io_rdata;
  logic [7:0] io_pass_wdata;
  logic [1:0] bm_irq_fwd;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_latch dut_i (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_rdata(cfg_rdata), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .bm_rdata(bm_rdata), .io_rdata(io_rdata), .io_pass_wdata(io_pass_wdata),
    .bm_irq_fwd(bm_irq_fwd)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drv_irq = '0; cfg_rd = 0; io_wr = 0; io_addr = 4'h1; io_wdata = '0; cfg_addr = '0;
  endtask

  // vendor byte as it should read back
  function automatic logic [7:0] vexp(input logic [3:0] n, input logic [1:0] f);
    return (8'(n) << 4) + (8'(f[1]) << 3) + (8'(f[0]) << 2);
  endfunction

  task automatic set_flags(input logic [1:0] f, input logic [3:0] n);
    idle(); io_wr = 1; io_wdata = {n, 4'b1100}; tick();
    idle(); drv_irq = f; tick();
    idle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 io1", io_rdata, 8'h00);
    cfg_addr = 8'h50; #1; chk("R1 cfg50", cfg_rdata, 8'h00);
    cfg_addr = 8'h57; #1; chk("R1 cfg57", cfg_rdata, 8'h00);
    idle(); @(negedge clk);

    // R2 set and stickiness
    for (int c = 0; c < 2; c++) begin
      set_flags(2'(1 << c), 4'h0);
      chk("R2 set", io_rdata, vexp(0, 2'(1 << c)));
      tick(); tick();
      chk("R2 sticky", io_rdata, vexp(0, 2'(1 << c)));
    end

    // R3 R4 R11 across all flag patterns
    for (int f = 0; f < 4; f++) begin
      set_flags(2'(f), 4'h0);
      cfg_rd = 1; cfg_addr = 8'h51; #1;
      chk("R11 other addr data", cfg_rdata, 8'h00);
      tick(); idle(); #1;
      chk("R11 no clear", io_rdata, vexp(0, 2'(f)));
      cfg_rd = 1; cfg_addr = 8'h50; #1;
      chk("R3 cfg50 data", cfg_rdata, 8'(f & 1) << 2);
      tick(); idle(); #1;
      chk("R3 cleared ch0", io_rdata, vexp(0, 2'(f & 2)));
      cfg_rd = 1; cfg_addr = 8'h57; #1;
      chk("R4 cfg57 data", cfg_rdata, 8'((f >> 1) & 1) << 4);
      tick(); idle(); #1;
      chk("R4 cleared ch1", io_rdata, 8'h00);
    end

    // R5 write-one-to-clear for every bit pair
    for (int w = 0; w < 4; w++) begin
      set_flags(2'b11, 4'h5);
      io_wr = 1; io_wdata = 8'(8'h50 | (w << 2)); tick(); idle(); #1;
      chk("R5 w1c", io_rdata, vexp(4'h5, 2'(3 & ~w)));
    end

    // R10 clear and set in same cycle
    set_flags(2'b00, 4'h0);
    drv_irq = 2'b01; io_wr = 1; io_wdata = 8'h0C; tick(); idle(); #1;
    chk("R10 io path", io_rdata, vexp(0, 2'b01));
    drv_irq = 2'b10; cfg_rd = 1; cfg_addr = 8'h57; tick(); idle(); #1;
    chk("R10 cfg path", io_rdata, vexp(0, 2'b11));

    // R6 nibble store sweep
    for (int n = 0; n < 16; n++) begin
      idle(); io_wr = 1; io_wdata = {4'(n), 4'b1111}; tick(); idle(); #1;
      chk("R6 readback", io_rdata, vexp(4'(n), 2'b00));
    end

    // R9 forwarding masks (stored bits 4,5) against every status pattern
    for (int m = 0; m < 4; m++) begin
      idle(); io_wr = 1; io_wdata = 8'(m << 4); tick(); idle();
      for (int d = 0; d < 4; d++) begin
        drv_irq = 2'(d); #1;
        chk("R9 fwd", 8'(bm_irq_fwd), 8'(d & ~m & 3));
      end
      idle(); tick();
    end

    // clear flags and set nibble to a known value for the overlay sweeps
    idle(); io_wr = 1; io_wdata = 8'hAC; tick(); idle(); #1;

    // R7 and R8 exhaustive combinational overlays
    for (int o = 0; o < 16; o++) begin
      for (int d = 0; d < 256; d++) begin
        io_addr = 4'(o); io_wdata = 8'(d); bm_rdata = 8'(d); #1;
        chk("R7 pass", io_pass_wdata, (o == 1) ? 8'(d & 3) : 8'(d));
        if (o == 1)                 chk("R8 vend", io_rdata, vexp(4'hA, 2'b00));
        else if (o == 2 || o == 10) chk("R8 status", io_rdata, 8'(d | 8));
        else                        chk("R8 other", io_rdata, 8'(d));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule